// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block is the counting core of an integer frequency synthesizer. On its feedback path a two-ratio prescaler model works with a swallow counter and a main counter. Together they produce one output pulse for every P×N + A cycles of the oscillator input. On its reference path a separate counter produces one pulse for every R cycles of the reference input. The phase comparator downstream compares the two pulse trains.

Both inputs arrive as one-cycle tick strobes in the block's clock domain. The feedback path counts cycles in which `vco_tick` is high. The reference path counts cycles in which `ref_tick` is high.

The ratio inputs are steady-state settings. The dividers sample them only when a division cycle ends, so a cycle that is already running is never cut short. A run/hold input parks both dividers. When the input is released, both dividers start from zero in the same clock edge, so the first comparison edges are aligned.

Top module: `pulse_swallow_divider`

## Requirements
- R1: `fb_pulse` is high once for every P×N + A cycles in which `vco_tick` is high, with 0 ≤ A < N and N ≥ 3. Cycles in which `vco_tick` is low do not advance the count. Within a period, the first A prescaler cycles last P+1 ticks and the remaining N−A cycles last P ticks.
- R2: `pre_low_sel` = 1 selects P = 64, a 64/65 prescaler. `pre_low_sel` = 0 selects P = 128, a 128/129 prescaler.
- R3: With `a_val` = 0, every prescaler cycle lasts P ticks, and the feedback period is exactly P×N ticks.
- R4: `ref_pulse` is high once for every R cycles in which `ref_tick` is high, with R from 3 to 16383.
- R5: Each output pulse lasts exactly one clock. It appears in the clock cycle that follows the clock edge consuming the tick that completes the count.
- R6: A change of `n_val`, `a_val`, `pre_low_sel` or `r_val` during a period does not alter that period. The new value governs the period that begins at the next terminal count.
- R7: While `run_en` is low, both pulse outputs stay low, both dividers are cleared, and the ratio inputs are loaded continuously.
- R8: On the clock edge where `run_en` is first seen high, both dividers start from zero. With equal ratios and ticks on every cycle, `fb_pulse` and `ref_pulse` rise in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | 1 = divide, 0 = hold both dividers cleared |
| vco_tick | input | 1 | Oscillator-side count strobe |
| ref_tick | input | 1 | Reference-side count strobe |
| pre_low_sel | input | 1 | Prescaler base: 1 = 64, 0 = 128 |
| a_val | input | 7 | Swallow count A |
| n_val | input | 11 | Main count N |
| r_val | input | 14 | Reference ratio R |
| fb_pulse | output | 1 | One-clock pulse per feedback period |
| ref_pulse | output | 1 | One-clock pulse per reference period |

## Verification
Two pairs of events can fall on the same clock edge.

The first pair is the feedback and reference terminal counts. The bench parks the block, sets R equal to P×N + A, forces ticks on every cycle and releases it. It then requires every feedback pulse to coincide with a reference pulse, and it counts the coincidences.

The second pair is a terminal count and a settings reload. New ratios are applied a few cycles after a feedback pulse. The scoreboard requires the in-flight period to keep the old length and the following periods to take the new one.

// File: rtl/psd_pkg.sv
package psd_pkg;

   localparam int unsigned PSD_P_LO = 64;
   localparam int unsigned PSD_A_W  = 7;
   localparam int unsigned PSD_N_W  = 11;
   localparam int unsigned PSD_R_W  = 14;

   typedef enum logic {
      MOD_BASE  = 1'b0,
      MOD_EXTRA = 1'b1
   } mod_e;

   function automatic int unsigned hi_mod(input int unsigned p_lo);
      return 2 * p_lo;
   endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
   import psd_pkg::*;
#(
   parameter int unsigned P_LO = PSD_P_LO
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic sel_lo,
   input  mod_e mode,
   output logic cyc_done
);
   localparam int unsigned P_HI = hi_mod(P_LO);
   localparam int unsigned CW   = $clog2(P_HI + 1);

   generate
      if (P_LO < 2) begin : g_bad_p
         $error("psd_prescaler: P_LO must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_c;

   always_comb begin
      last_c = sel_lo ? CW'(P_LO - 1) : CW'(P_HI - 1);
      if (mode == MOD_EXTRA) last_c = last_c + CW'(1);
   end

   assign cyc_done = run && tick && (cnt_q == last_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (tick)     cnt_q <= cyc_done ? '0 : cnt_q + CW'(1);
   end

   // R1
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(P_HI));

endmodule

// File: rtl/psd_swallow_main.sv
module psd_swallow_main
   import psd_pkg::*;
#(
   parameter int unsigned A_W = PSD_A_W,
   parameter int unsigned N_W = PSD_N_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           cyc_done,
   input  logic [A_W-1:0] ld_a,
   input  logic [N_W-1:0] ld_n,
   output mod_e           mode,
   output logic           frame_end,
   output logic           fb_pulse
);
   generate
      if (A_W < 1 || A_W >= N_W) begin : g_bad_w
         $error("psd_swallow_main: need 1 <= A_W < N_W");
      end
   endgenerate

   logic [A_W-1:0] swal_q;
   logic [N_W-1:0] main_q;

   assign mode      = (swal_q != '0) ? MOD_EXTRA : MOD_BASE;
   assign frame_end = cyc_done && (main_q == N_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swal_q   <= '0;
         main_q   <= '0;
         fb_pulse <= 1'b0;
      end else if (!run) begin
         swal_q   <= ld_a;
         main_q   <= ld_n;
         fb_pulse <= 1'b0;
      end else begin
         fb_pulse <= frame_end;
         if (frame_end) begin
            swal_q <= ld_a;
            main_q <= ld_n;
         end else if (cyc_done) begin
            main_q <= main_q - N_W'(1);
            if (swal_q != '0) swal_q <= swal_q - A_W'(1);
         end
      end
   end

   // R5
   fb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_pulse |=> !fb_pulse);

   // R7
   fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !fb_pulse);

endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div
   import psd_pkg::*;
#(
   parameter int unsigned R_W = PSD_R_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run,
   input  logic           tick,
   input  logic [R_W-1:0] ld_r,
   output logic           ref_pulse
);
   generate
      if (R_W < 2) begin : g_bad_r
         $error("psd_ref_div: R_W must be at least 2");
      end
   endgenerate

   logic [R_W-1:0] r_act_q;
   logic [R_W-1:0] cnt_q;
   logic           term;

   assign term = run && tick && (cnt_q == r_act_q - R_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_act_q   <= '0;
         cnt_q     <= '0;
         ref_pulse <= 1'b0;
      end else if (!run) begin
         r_act_q   <= ld_r;
         cnt_q     <= '0;
         ref_pulse <= 1'b0;
      end else begin
         ref_pulse <= term;
         if (term) begin
            cnt_q   <= '0;
            r_act_q <= ld_r;
         end else if (tick) begin
            cnt_q <= cnt_q + R_W'(1);
         end
      end
   end

   // R5
   ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pulse |=> !ref_pulse);

   // R4
   ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> (cnt_q < r_act_q));

   // R7
   ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !ref_pulse);

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
   import psd_pkg::*;
#(
   parameter int unsigned P_LO = PSD_P_LO,
   parameter int unsigned A_W  = PSD_A_W,
   parameter int unsigned N_W  = PSD_N_W,
   parameter int unsigned R_W  = PSD_R_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           run_en,
   input  logic           vco_tick,
   input  logic           ref_tick,
   input  logic           pre_low_sel,
   input  logic [A_W-1:0] a_val,
   input  logic [N_W-1:0] n_val,
   input  logic [R_W-1:0] r_val,
   output logic           fb_pulse,
   output logic           ref_pulse
);
   logic sw_act_q;
   logic cyc_done;
   logic frame_end;
   mod_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sw_act_q <= 1'b1;
      else if (!run_en || frame_end) sw_act_q <= pre_low_sel;
   end

   psd_prescaler #(.P_LO(P_LO)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_en),
      .tick     (vco_tick),
      .sel_lo   (sw_act_q),
      .mode     (mode),
      .cyc_done (cyc_done)
   );

   psd_swallow_main #(.A_W(A_W), .N_W(N_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_en),
      .cyc_done  (cyc_done),
      .ld_a      (a_val),
      .ld_n      (n_val),
      .mode      (mode),
      .frame_end (frame_end),
      .fb_pulse  (fb_pulse)
   );

   psd_ref_div #(.R_W(R_W)) u_ref (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_en),
      .tick      (ref_tick),
      .ld_r      (r_val),
      .ref_pulse (ref_pulse)
   );

   // R6
   sw_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_en) && !$stable(sw_act_q)) |-> fb_pulse);

endmodule

// File: tb/pulse_swallow_divider_test.sv
module pulse_swallow_divider_test;

   typedef struct {
      int    ratio;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic        vco_tick = 1'b0;
   logic        ref_tick = 1'b0;
   logic        pre_low_sel = 1'b1;
   logic [6:0]  a_val = '0;
   logic [10:0] n_val = 11'd3;
   logic [13:0] r_val = 14'd200;
   logic        fb_pulse;
   logic        ref_pulse;

   int   checks = 0;
   int   errors = 0;
   exp_t fb_q[$];
   int   exp_r = 200;
   int   cur_ratio = 0;
   int   fb_ticks = 0;
   int   ref_ticks = 0;
   int   coinc = 0;
   bit   dense = 0;
   bit   aligned = 0;
   bit   fb_prev = 0;
   bit   ref_prev = 0;
   bit   done = 0;
   bit   timeout = 0;

   always #4 clk = ~clk;

   pulse_swallow_divider uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .vco_tick    (vco_tick),
      .ref_tick    (ref_tick),
      .pre_low_sel (pre_low_sel),
      .a_val       (a_val),
      .n_val       (n_val),
      .r_val       (r_val),
      .fb_pulse    (fb_pulse),
      .ref_pulse   (ref_pulse)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   always @(posedge clk) begin
      #1;
      vco_tick = dense ? 1'b1 : ($urandom_range(3) != 0);
      ref_tick = dense ? 1'b1 : ($urandom_range(3) != 0);
   end

   // monitor: pops expected feedback periods and checks the reference period
   always @(negedge clk) begin
      if (!rst_n || !run_en) begin
         fb_ticks  = 0;
         ref_ticks = 0;
         fb_prev   = 0;
         ref_prev  = 0;
      end else begin
         if (fb_pulse) begin
            check(!fb_prev, "R5 feedback pulse width", 2, 1);
            if (fb_q.size() == 0) begin
               check(1'b0, "R1 unexpected feedback pulse", fb_ticks, 0);
            end else begin
               exp_t it;
               it = fb_q.pop_front();
               check(fb_ticks == it.ratio, it.tag, fb_ticks, it.ratio);
            end
            fb_ticks = 0;
         end
         if (ref_pulse) begin
            check(!ref_prev, "R5 reference pulse width", 2, 1);
            check(ref_ticks == exp_r, "R4 reference period", ref_ticks, exp_r);
            ref_ticks = 0;
         end
         if (aligned && (fb_pulse || ref_pulse)) begin
            check(fb_pulse == ref_pulse, "R8 pulse alignment", int'(fb_pulse), int'(ref_pulse));
            if (fb_pulse && ref_pulse) coinc++;
         end
         fb_prev  = fb_pulse;
         ref_prev = ref_pulse;
         if (vco_tick) fb_ticks++;
         if (ref_tick) ref_ticks++;
      end
   end

   task automatic program_ratio(input int n, input int a, input bit s,
                                input int frames, input string tag);
      int p;
      int nr;
      p  = s ? 64 : 128;
      nr = p * n + a;
      @(posedge clk); #1;
      n_val       = 11'(n);
      a_val       = 7'(a);
      pre_low_sel = s;
      fb_q.push_back('{cur_ratio, "R6 in-flight period keeps old ratio"});
      for (int i = 0; i < frames; i++) fb_q.push_back('{nr, tag});
      cur_ratio = nr;
      wait (fb_q.size() == 0);
   endtask

   task automatic run_all;
      // reset state: no pulses while held (R7)
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(!fb_pulse && !ref_pulse, "R7 reset outputs low", int'(fb_pulse | ref_pulse), 0);
      end
      @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      // R3: A = 0 gives P*N, P = 64
      for (int i = 0; i < 3; i++) fb_q.push_back('{192, "R3 A=0 period"});
      cur_ratio = 192;
      @(posedge clk); #1;
      run_en = 1'b1;
      wait (fb_q.size() == 0);
      // R1: swallow adds A ticks
      program_ratio(3, 2, 1'b1, 2, "R1 swallow period 64x3+2");
      // R2: 128/129 prescaler selected by pre_low_sel = 0
      program_ratio(5, 4, 1'b0, 2, "R2 prescaler 128 period");
      program_ratio(4, 1, 1'b1, 2, "R2 prescaler 64 period");
      // R7: hold mid-period
      repeat (50) @(posedge clk);
      #1;
      run_en = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         check(!fb_pulse && !ref_pulse, "R7 hold outputs low", int'(fb_pulse | ref_pulse), 0);
      end
      fb_q.delete();
      @(posedge clk); #1;
      n_val       = 11'd3;
      a_val       = 7'd1;
      pre_low_sel = 1'b1;
      r_val       = 14'd193;
      exp_r       = 193;
      dense       = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      aligned = 1'b1;
      coinc   = 0;
      for (int i = 0; i < 3; i++) fb_q.push_back('{193, "R8 first periods after release"});
      cur_ratio = 193;
      run_en = 1'b1;
      wait (fb_q.size() == 0);
      @(negedge clk);
      check(coinc == 3, "R8 coincident pulses", coinc, 3);
      done = 1'b1;
   endtask

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) timeout = 1'b1;
   end

   initial begin
      fork
         run_all();
      join_none
      wait (done || timeout);
      if (timeout) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired: actual=hung expected=finished");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule